// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block makes the serial clock for an SPI controller out of the module clock. Two codes set the serial clock period. A 2-bit prescaler code selects an odd or small factor. A 4-bit scaler code selects a factor from a table that is not uniform. The period in module clocks is the product of the two factors. An optional double-rate bit halves that product, but only for the three smallest scaler factors.

The block gives two outputs. One is a one-cycle toggle enable that fires at the end of every half period. The other is the serial clock level, which starts each frame at the programmed idle polarity. The block counts only while a transfer is active. A frame-start pulse loads the codes and the polarity and restarts the count. Code values change nothing between frame starts, so software may rewrite them at any time. Choosing codes for a target frequency is done outside the block, and so are the chip-select to clock delays.

Top module: `sckgen_baud`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sck` is 0 and `sck_toggle` is 0.
- R2: Prescaler code 0, 1, 2, 3 selects a factor of 2, 3, 5, 7.
- R3: Scaler code 0..3 selects 2, 4, 6, 8. Scaler code k for k = 4..15 selects 2^k, so code 4 gives 16 and code 15 gives 32768.
- R4: The serial clock period D in module clocks is the prescaler factor times the scaler factor. The high level lasts floor(D/2) cycles and the low level lasts D - floor(D/2) cycles, so an odd D gives a high phase one cycle shorter than the low phase.
- R5: With `dbl_rate` set and scaler code 0, 1 or 2, D is halved. With any other scaler code, `dbl_rate` has no effect on the period.
- R6: The cycle after `frame_start`, `sck` equals the `idle_pol` value sampled with that pulse, and the count begins from zero.
- R7: While `xfer_active` is low, `sck_toggle` stays 0 and `sck` returns to the latched idle polarity on the next cycle.
- R8: A `frame_start` in the middle of a half period drops the partial count. The next toggle comes a full half period after the pulse.
- R9: Changes to the codes, `dbl_rate` or `idle_pol` without a `frame_start` leave the period and levels unchanged.
- R10: `sck_toggle` is high for exactly the last cycle of each half period, and `sck` inverts on the following cycle. While active and with no frame start, `sck` changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_active | input | 1 | High while a transfer runs. Enables counting. |
| frame_start | input | 1 | One-cycle pulse that loads the configuration and restarts the count |
| pre_code | input | 2 | Prescaler code |
| scl_code | input | 4 | Scaler code |
| dbl_rate | input | 1 | Halves the divide for small scaler codes |
| idle_pol | input | 1 | Serial clock level between frames |
| sck | output | 1 | Serial clock level |
| sck_toggle | output | 1 | Half-period toggle enable |

## Verification
The assertions assume that `frame_start` is a clean one-cycle pulse, and that the configuration inputs only matter in the cycle where that pulse is high. They place no timing constraint on `xfer_active`. The stimulus changes inputs only at the falling edge. It holds `frame_start` high for exactly one cycle each time, rewrites the codes in the middle of frames, and drops `xfer_active` without warning. The reference model runs on every cycle and checks that the design behaves the same under all of these inputs.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;

  localparam int PRE_W = 2;
  localparam int SCL_W = 4;
  // scaler codes at or below this value allow the halved divide
  localparam int DBL_MAX_CODE = 2;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SCL_W-1:0] scl;
    logic             dbl;
    logic             idle;
  } sck_cfg_t;

  // Prescaler factor: odd or small values, so no shift will do
  function automatic logic [31:0] pre_factor(input logic [PRE_W-1:0] code);
    logic [31:0] f;
    case (code)
      2'd0:    f = 32'd2;
      2'd1:    f = 32'd3;
      2'd2:    f = 32'd5;
      default: f = 32'd7;
    endcase
    return f;
  endfunction

  // Scaler factor: linear steps at the low end, powers of two above
  function automatic logic [31:0] scl_factor(input logic [SCL_W-1:0] code);
    logic [31:0] f;
    if (code < 4) f = 32'(2 * (int'(code) + 1));
    else          f = 32'd1 << code;
    return f;
  endfunction

endpackage

// File: rtl/sckgen_divsel.sv
module sckgen_divsel
  import sckgen_pkg::*;
#(
  parameter int  DIV_W  = 18,
  parameter bit  DBL_EN = 1'b1,
  localparam int HALF_W = DIV_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  sck_cfg_t          cfg_in,
  output logic [HALF_W-1:0] hi_len,
  output logic [HALF_W-1:0] lo_len,
  output logic              idle_q
);

  sck_cfg_t         cfg_q, cfg_d;
  logic [31:0]      full_div;
  logic [DIV_W-1:0] total_div;
  logic             halve;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign full_div = pre_factor(cfg_q.pre) * scl_factor(cfg_q.scl);

  generate
    if (DBL_EN) begin : g_dbl
      assign halve = cfg_q.dbl && (int'(cfg_q.scl) <= DBL_MAX_CODE);
    end else begin : g_nodbl
      assign halve = 1'b0;
    end
  endgenerate

  always_comb begin
    if (halve) total_div = full_div[DIV_W:1];
    else       total_div = full_div[DIV_W-1:0];
  end

  // high half is the shorter one for odd totals
  assign hi_len = total_div[DIV_W-1:1];
  assign lo_len = HALF_W'(total_div - {1'b0, hi_len});
  assign idle_q = cfg_q.idle;

  // R9: the divide only moves on a load
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(total_div));

  // R4: the phases differ by at most one cycle and are never empty
  a_r4_phase_split: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_len != '0) && (lo_len >= hi_len) && (lo_len - hi_len <= 1));

endmodule

// File: rtl/sckgen_phase_cnt.sv
module sckgen_phase_cnt #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             level,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cur_len;

  assign cur_len = level ? hi_len : lo_len;
  assign tick    = run && !restart && (cnt_q == cur_len - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run) cnt_d = '0;
    else if (tick)       cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: the count never passes the length of the current phase
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |-> (cnt_q < cur_len));

  // R7: no count is kept while idle
  a_r7_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/sckgen_baud.sv
module sckgen_baud
  import sckgen_pkg::*;
#(
  parameter bit  DBL_EN = 1'b1,
  localparam int DIV_W  = 3 + (1 << SCL_W) - 1,
  localparam int HALF_W = DIV_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_active,
  input  logic             frame_start,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [SCL_W-1:0] scl_code,
  input  logic             dbl_rate,
  input  logic             idle_pol,
  output logic             sck,
  output logic             sck_toggle
);

  sck_cfg_t          cfg_in;
  logic [HALF_W-1:0] hi_len;
  logic [HALF_W-1:0] lo_len;
  logic              idle_q;
  logic              sck_q, sck_d;
  logic              tick;

  assign cfg_in = '{pre: pre_code, scl: scl_code, dbl: dbl_rate, idle: idle_pol};

  sckgen_divsel #(.DIV_W(DIV_W), .DBL_EN(DBL_EN)) u_divsel (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (frame_start),
    .cfg_in (cfg_in),
    .hi_len (hi_len),
    .lo_len (lo_len),
    .idle_q (idle_q)
  );

  sckgen_phase_cnt #(.CNT_W(HALF_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (xfer_active),
    .restart (frame_start),
    .level   (sck_q),
    .hi_len  (hi_len),
    .lo_len  (lo_len),
    .tick    (tick)
  );

  always_comb begin
    sck_d = sck_q;
    if (frame_start)      sck_d = idle_pol;
    else if (!xfer_active) sck_d = idle_q;
    else if (tick)        sck_d = ~sck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_d;
  end

  assign sck        = sck_q;
  assign sck_toggle = tick;

  // R10: a toggle enable inverts the level on the next cycle
  a_r10_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    sck_toggle |=> (sck != $past(sck)));

  // R10: while running with no enable and no restart the level holds
  a_r10_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !frame_start && !sck_toggle) |=> $stable(sck));

  // R6: a frame begins at the sampled idle polarity
  a_r6_start_level: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (sck == $past(idle_pol)));

  // R7: no toggle enable while idle
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> !sck_toggle);

endmodule

// File: tb/test_sckgen_baud.sv
`timescale 1ns/1ps
module test_sckgen_baud;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       xfer_active, frame_start, dbl_rate, idle_pol;
  logic [1:0] pre_code;
  logic [3:0] scl_code;
  logic       sck, sck_toggle;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_div, m_cnt;
  bit m_sck, m_idle;
  // measurement
  int cyc = 0, last_rise = -1, last_fall = -1, period_seen = 0, hi_seen = 0;
  bit prev_sck = 0;

  int pre_tab[4]  = '{2, 3, 5, 7};
  int scl_tab[16] = '{2, 4, 6, 8, 16, 32, 64, 128, 256, 512, 1024, 2048,
                      4096, 8192, 16384, 32768};

  always #2.5 clk = ~clk;

  sckgen_baud i_sckgen_baud (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active),
    .frame_start(frame_start), .pre_code(pre_code), .scl_code(scl_code),
    .dbl_rate(dbl_rate), .idle_pol(idle_pol), .sck(sck),
    .sck_toggle(sck_toggle));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic bit model_tick();
    int len;
    len = m_sck ? (m_div / 2) : (m_div - m_div / 2);
    return xfer_active && !frame_start && (m_cnt == len - 1);
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      bit t;
      @(posedge clk);
      t = model_tick();
      if (frame_start) begin
        m_div = pre_tab[pre_code] * scl_tab[scl_code];
        if (dbl_rate && scl_code <= 2) m_div = m_div / 2;
        m_idle = idle_pol; m_cnt = 0; m_sck = idle_pol;
      end else if (!xfer_active) begin
        m_cnt = 0; m_sck = m_idle;
      end else if (t) begin
        m_cnt = 0; m_sck = !m_sck;
      end else begin
        m_cnt++;
      end
      @(negedge clk);
      cyc++;
      check({cur_req, " sck"}, int'(sck), int'(m_sck));
      check({cur_req, " toggle"}, int'(sck_toggle), int'(model_tick()));
      if (sck && !prev_sck) begin
        if (last_rise >= 0) period_seen = cyc - last_rise;
        last_rise = cyc;
      end
      if (!sck && prev_sck) begin
        last_fall = cyc;
        if (last_rise >= 0) hi_seen = cyc - last_rise;
      end
      prev_sck = sck;
    end
  endtask

  task automatic new_frame(input int p, input int s, input bit d, input bit ip);
    pre_code = 2'(p); scl_code = 4'(s); dbl_rate = d; idle_pol = ip;
    frame_start = 1'b1;
    step(1);
    frame_start = 1'b0;
    last_rise = -1; period_seen = 0; hi_seen = 0;
  endtask

  initial begin
    rst_n = 1'b0; xfer_active = 0; frame_start = 0;
    pre_code = 0; scl_code = 0; dbl_rate = 0; idle_pol = 0;
    m_div = 4; m_cnt = 0; m_sck = 0; m_idle = 0;
    #1;
    check("R1 reset sck", int'(sck), 0);
    check("R1 reset toggle", int'(sck_toggle), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(2);
    check("R1 after reset sck", int'(sck), 0);

    // R2/R3/R4: 3*4 = 12
    cur_req = "R4"; xfer_active = 1;
    new_frame(1, 1, 0, 0);
    step(60);
    check("R4 period 3x4", period_seen, 12);
    check("R4 high 3x4", hi_seen, 6);

    // R2: 5*2 = 10
    cur_req = "R2";
    new_frame(2, 0, 0, 0);
    step(50);
    check("R2 period 5x2", period_seen, 10);

    // R3: 2*2048
    cur_req = "R3";
    new_frame(0, 11, 0, 0);
    step(9000);
    check("R3 period 2x2048", period_seen, 4096);

    // R5 + R4 odd: 7*2/2 = 7, high 3
    cur_req = "R5";
    new_frame(3, 0, 1, 0);
    step(40);
    check("R5 halved period", period_seen, 7);
    check("R4 odd high phase", hi_seen, 3);

    // R5 ignored: 2*16 = 32
    new_frame(0, 4, 1, 0);
    step(120);
    check("R5 double ignored", period_seen, 32);

    // R6: idle high
    cur_req = "R6";
    new_frame(1, 0, 0, 1);
    check("R6 start level", int'(sck), 1);
    step(30);
    check("R6 period", period_seen, 6);

    // R9: change codes without frame start
    cur_req = "R9";
    pre_code = 3; scl_code = 5; dbl_rate = 1; idle_pol = 0;
    step(30);
    check("R9 period unchanged", period_seen, 6);

    // R8: restart mid phase, 5*4 = 20, low half 10
    cur_req = "R8";
    new_frame(2, 1, 0, 0);
    step(4);
    new_frame(2, 1, 0, 0);
    step(9);
    check("R8 no early toggle", int'(sck), 0);
    step(1);
    check("R8 toggle after full half", int'(sck), 1);

    // R7: drop active
    cur_req = "R7";
    step(3);
    xfer_active = 0;
    step(1);
    check("R7 idle level", int'(sck), 0);
    step(20);
    check("R7 no toggle", int'(sck_toggle), 0);
    xfer_active = 1;
    step(25);

    cur_req = "R10";
    new_frame(0, 0, 1, 1);
    step(10);
    check("R10 fastest period", period_seen, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule